// File: doc/BRIEF.md
# Multiprocessor UART receiver with address filtering

This block receives asynchronous serial frames and decides for each whether it is handed to software. It supports an 8-bit frame (start, eight data bits sent LSB first, stop) and a 9-bit frame (start, eight data bits, a ninth bit, stop). The line is sampled on a 16x oversampling tick supplied from outside. Each bit is decided at mid-bit by a 2-of-3 majority vote.

A finished frame is committed to the output registers only when the receive-complete flag is clear and the filtering condition holds. Otherwise it is dropped without trace. In 9-bit mode with multiprocessor filtering on, only address frames (ninth bit 1) pass. They must also match either the given address or the broadcast address. Both addresses are built from a slave address and an enable mask. Software clears the flags and loads the address and mask through a small write port.

The frame state machine has states IDLE, START, DATA, NINTH and STOP. Its transitions are:
- IDLE to START on a tick that samples the line low.
- START back to IDLE when the mid-bit vote reads high (a false start).
- START to DATA at the end of the start bit.
- DATA to NINTH (9-bit mode) or to STOP (8-bit mode) at the end of the eighth data bit.
- NINTH to STOP at the end of the ninth bit.
- STOP to IDLE at the mid-bit vote of the stop bit. This is the point where the commit decision is taken.

Top module: `mpr_uart_rx`

## Requirements
- R1: After reset, rx_byte, rx_bit9, rx_done and frame_err are all 0, and the slave address and mask registers are 0.
- R2: With mode9=0 and mp_en=0, a frame with a high stop bit is committed. rx_byte holds the eight data bits (the first received bit in bit 0), rx_bit9 takes the stop bit value, and rx_done is set.
- R3: When rx_done is already 1, a new frame is lost. rx_byte and rx_bit9 keep their values.
- R4: With mode9=1 and mp_en=0, every frame is committed, and rx_bit9 takes the received ninth bit, whether it is 0 or 1.
- R5: With mode9=1 and mp_en=1, a frame whose ninth bit is 0 (a data frame) is discarded.
- R6: With mode9=1 and mp_en=1, an address frame is committed when (rx & mask) equals (saddr & mask).
- R7: With mode9=1 and mp_en=1, an address frame is also committed when every bit that is 1 in (saddr | mask) is also 1 in the received byte. An address frame that matches neither pattern is discarded.
- R8: With mode9=0 and mp_en=1, a frame whose stop bit samples low is discarded.
- R9: frame_err is set whenever a stop bit samples low, whether or not the frame is committed, and stays 1 until software clears it. A low stop bit does not block a commit in 9-bit mode.
- R10: A low pulse on rxd whose mid-bit vote of the start bit reads high is a false start. No frame is produced, and the next proper frame is received normally.
- R11: A one-tick low glitch inside a high data bit does not change the decided bit value.
- R12: A write with wr_sel=0 clears rx_done when wr_data[0]=1 and clears frame_err when wr_data[1]=1. wr_sel=1 loads the slave address, and wr_sel=2 loads the mask. A commit or framing error in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| mode9 | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| mp_en | input | 1 | Multiprocessor filtering enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 flag clear, 1 slave address, 2 mask |
| wr_data | input | 8 | Write data |
| rx_byte | output | 8 | Last committed data byte |
| rx_bit9 | output | 1 | Last committed ninth bit (stop bit in 8-bit mode) |
| rx_done | output | 1 | Receive-complete flag, cleared by software |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
The assertions assume that mode9 and mp_en stay fixed from the start bit until the commit decision. They also assume that rx_done changes only through a commit or a clear write. The bench therefore changes mode and filtering only while the line is idle, between frames. Ticks arrive every fourth clock, and glitches are at most three clocks wide. As a result, a glitch can corrupt at most one of the three votes.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_e;

    localparam logic [1:0] SEL_FLAGS = 2'd0;
    localparam logic [1:0] SEL_SADDR = 2'd1;
    localparam logic [1:0] SEL_MASK  = 2'd2;

    localparam int CLR_DONE_BIT = 0;
    localparam int CLR_FERR_BIT = 1;

endpackage

// File: rtl/mpr_sampler.sv
module mpr_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic tick,
    output logic line_o,
    output logic maj_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
            if (tick) begin
                hist_q <= {hist_q[0], line_o};
            end
        end
    end

    assign line_o = sync_q[SYNC_STAGES-1];
    assign maj_o  = (hist_q[1] & hist_q[0]) | (hist_q[1] & line_o) | (hist_q[0] & line_o);

endmodule

// File: rtl/mpr_frame_fsm.sv
module mpr_frame_fsm
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              maj,
    input  logic              mode9,
    output logic [DATA_W-1:0] data_q,
    output logic              ninth_q,
    output logic              stop_q,
    output logic              done_evt
);

    localparam int                CNT_W    = $clog2(OVS);
    localparam int                IDX_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  MID      = CNT_W'(OVS / 2);
    localparam logic [CNT_W-1:0]  LAST     = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             at_mid, at_end;

    assign at_mid = tick && (cnt_q == MID);
    assign at_end = tick && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick && !line) state_d = ST_START;
            ST_START: begin
                if (at_mid && maj)  state_d = ST_IDLE;
                else if (at_end)    state_d = ST_DATA;
            end
            ST_DATA:  if (at_end && idx_q == LAST_IDX) state_d = mode9 ? ST_NINTH : ST_STOP;
            ST_NINTH: if (at_end) state_d = ST_STOP;
            ST_STOP:  if (at_mid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            idx_q    <= '0;
            data_q   <= '0;
            ninth_q  <= 1'b0;
            stop_q   <= 1'b1;
            done_evt <= 1'b0;
        end else begin
            done_evt <= (state_q == ST_STOP) && at_mid;
            if (state_q == ST_IDLE)  cnt_q <= '0;
            else if (at_end)         cnt_q <= '0;
            else if (tick)           cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_START && at_end) idx_q <= '0;
            if (state_q == ST_DATA) begin
                if (at_mid) data_q <= {maj, data_q[DATA_W-1:1]};
                if (at_end) idx_q  <= idx_q + 1'b1;
            end
            if (state_q == ST_NINTH && at_mid) ninth_q <= maj;
            if (state_q == ST_STOP && at_mid)  stop_q  <= maj;
        end
    end

    AST_EVT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> $past(state_q) == ST_STOP && state_q == ST_IDLE); // R2

    AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q) == ST_START && state_q == ST_IDLE |-> !done_evt); // R10

endmodule

// File: rtl/mpr_addr_match.sv
module mpr_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx,
    input  logic [W-1:0] saddr,
    input  logic [W-1:0] mask,
    output logic         given_hit,
    output logic         bcast_hit
);

    logic [W-1:0] bcast_pat;

    assign bcast_pat = saddr | mask;
    assign given_hit = ((rx & mask) == (saddr & mask));
    assign bcast_hit = ((rx & bcast_pat) == bcast_pat);

endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic              mode9,
    input  logic              mp_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              frame_err
);

    logic              line, maj;
    logic [DATA_W-1:0] frm_data;
    logic              frm_ninth, frm_stop, frm_evt;
    logic [DATA_W-1:0] saddr_q, mask_q;
    logic              given_hit, bcast_hit;
    logic              accept, clr_done, clr_fe;

    mpr_sampler #(.SYNC_STAGES(2)) u_samp (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick(os_tick),
        .line_o(line), .maj_o(maj)
    );

    mpr_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line), .maj(maj),
        .mode9(mode9), .data_q(frm_data), .ninth_q(frm_ninth),
        .stop_q(frm_stop), .done_evt(frm_evt)
    );

    mpr_addr_match #(.W(DATA_W)) u_match (
        .rx(frm_data), .saddr(saddr_q), .mask(mask_q),
        .given_hit(given_hit), .bcast_hit(bcast_hit)
    );

    assign clr_done = wr_en && wr_sel == SEL_FLAGS && wr_data[CLR_DONE_BIT];
    assign clr_fe   = wr_en && wr_sel == SEL_FLAGS && wr_data[CLR_FERR_BIT];

    always_comb begin
        if (mode9) accept = !mp_en || (frm_ninth && (given_hit || bcast_hit));
        else       accept = !mp_en || frm_stop;
        accept = accept && !rx_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            rx_bit9   <= 1'b0;
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
            saddr_q   <= '0;
            mask_q    <= '0;
        end else begin
            if (frm_evt && accept) begin
                rx_byte <= frm_data;
                rx_bit9 <= mode9 ? frm_ninth : frm_stop;
                rx_done <= 1'b1;
            end else if (clr_done) begin
                rx_done <= 1'b0;
            end
            if (frm_evt && !frm_stop) frame_err <= 1'b1;
            else if (clr_fe)          frame_err <= 1'b0;
            if (wr_en && wr_sel == SEL_SADDR) saddr_q <= wr_data;
            if (wr_en && wr_sel == SEL_MASK)  mask_q  <= wr_data;
        end
    end

    AST_DONE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(frm_evt)); // R2

    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_done) |-> $stable(rx_byte) && $stable(rx_bit9)); // R3

    AST_MP9_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) && $past(mode9) && $past(mp_en) |-> rx_bit9); // R5

    AST_MP8_STOP_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) && !$past(mode9) && $past(mp_en) |-> rx_bit9 && $past(frm_stop)); // R8

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_err) && !$past(clr_fe) |-> frame_err); // R9

endmodule

// File: tb/sim_mpr_uart_rx.sv
module sim_mpr_uart_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick;
    logic       mode9 = 1'b0;
    logic       mp_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rx_byte;
    logic       rx_bit9, rx_done, frame_err;

    int checks = 0;
    int bad = 0;
    logic [1:0] tdiv = 2'd0;

    typedef struct {
        logic       done;
        logic [7:0] dat;
        logic       bit9;
        logic       ferr;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic       m_done = 1'b0, m_bit9 = 1'b0, m_ferr = 1'b0;
    logic [7:0] m_byte = 8'd0, m_saddr = 8'd0, m_mask = 8'd0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);

    mpr_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .mode9(mode9), .mp_en(mp_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
        .rx_done(rx_done), .frame_err(frame_err)
    );

    task automatic check1(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    // monitor: pops expected snapshots and compares the ports
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check1(e.tag, "rx_done", int'(rx_done), int'(e.done));
                check1(e.tag, "rx_byte", int'(rx_byte), int'(e.dat));
                check1(e.tag, "rx_bit9", int'(rx_bit9), int'(e.bit9));
                check1(e.tag, "frame_err", int'(frame_err), int'(e.ferr));
            end
        end
    end

    task automatic push_exp(string tag);
        exp_t e;
        e.done = m_done; e.dat = m_byte; e.bit9 = m_bit9; e.ferr = m_ferr; e.tag = tag;
        exp_q.push_back(e);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 2'd0) begin
            if (d[0]) m_done = 1'b0;
            if (d[1]) m_ferr = 1'b0;
        end else if (sel == 2'd1) m_saddr = d;
        else if (sel == 2'd2) m_mask = d;
    endtask

    task automatic drive_bit(logic b, bit glitch);
        rxd = b;
        if (glitch) begin
            repeat (30) @(negedge clk);
            rxd = ~b;
            repeat (3) @(negedge clk);
            rxd = b;
            repeat (31) @(negedge clk);
        end else begin
            repeat (64) @(negedge clk);
        end
    endtask

    task automatic send(string tag, logic m9, logic mp, logic [7:0] d,
                        logic ninth, logic stop, bit glitch);
        logic ok;
        @(negedge clk);
        mode9 = m9; mp_en = mp;
        repeat (8) @(negedge clk);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i], glitch);
        if (m9) drive_bit(ninth, 1'b0);
        drive_bit(stop, 1'b0);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        // reference decision from the requirements
        if (m9) ok = !mp || (ninth && ((((d & m_mask) == (m_saddr & m_mask))) ||
                                       ((d & (m_saddr | m_mask)) == (m_saddr | m_mask))));
        else    ok = !mp || stop;
        if (!stop) m_ferr = 1'b1;
        if (ok && !m_done) begin
            m_done = 1'b1; m_byte = d; m_bit9 = m9 ? ninth : stop;
        end
        push_exp(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        push_exp("R1");
        wr(2'd1, 8'h35);
        wr(2'd2, 8'hF0);                       // R12 address and mask load
        send("R2", 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0);
        send("R3", 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0);
        wr(2'd0, 8'h01);
        push_exp("R12");
        send("R4", 1'b1, 1'b0, 8'h11, 1'b0, 1'b1, 1'b0);
        wr(2'd0, 8'h01);
        send("R5", 1'b1, 1'b1, 8'h30, 1'b0, 1'b1, 1'b0);
        send("R6", 1'b1, 1'b1, 8'h3A, 1'b1, 1'b1, 1'b0);
        wr(2'd0, 8'h01);
        send("R7", 1'b1, 1'b1, 8'h47, 1'b1, 1'b1, 1'b0);
        send("R7", 1'b1, 1'b1, 8'hFD, 1'b1, 1'b1, 1'b0);
        wr(2'd0, 8'h01);
        send("R8", 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0);
        wr(2'd0, 8'h01);
        push_exp("R9");                        // error survives done-only clear
        send("R9", 1'b0, 1'b0, 8'h77, 1'b0, 1'b1, 1'b0);
        wr(2'd0, 8'h03);
        push_exp("R12");
        send("R9", 1'b1, 1'b0, 8'h81, 1'b1, 1'b0, 1'b0);
        wr(2'd0, 8'h03);
        // R10: short low pulse, then a proper frame
        @(negedge clk);
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (128) @(negedge clk);
        push_exp("R10");
        send("R10", 1'b0, 1'b0, 8'h96, 1'b0, 1'b1, 1'b0);
        wr(2'd0, 8'h01);
        send("R11", 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h00);                       // R12 mask reload
        send("R12", 1'b1, 1'b1, 8'h12, 1'b1, 1'b1, 1'b0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule